// File: doc/BRIEF.md
# Pipelined Microcontroller Execute Stage

This block is the last stage of a small three-stage pipelined microcontroller. It holds the register file (16 entries of 32 bits) together with the execute logic. Each cycle it accepts one decoded command with two source indices, a destination index and a 32-bit immediate. It reads its operands, computes the result, writes the result back on the next rising clock edge, and registers its side effects.

Eight commands are supported. MOVE, ADD, SUB, MUL and LOAD write a register. READ drives a register's contents onto an external data port together with a one-cycle valid strobe. CJE compares two registers. When they are equal it raises `jump_o` and `flush_o` for one cycle so that the upstream stages turn their in-flight instructions into NOPs. NOP, which is also what a squashed instruction becomes, has no effect.

Results are written at the clock edge that ends the cycle. The instruction presented in the very next cycle therefore already reads the new value, so back-to-back dependent instructions need no stall.

Top module: `mcu_exec_stage`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears all 16 registers and `out_data_o` to zero, and holds `out_valid_o`, `jump_o` and `flush_o` low.
- R2: Command code 3'b000 (MOVE) writes register[src_a] into register[dst].
- R3: Command code 3'b001 (ADD) writes register[src_a] + register[src_b], modulo 2^32, into register[dst].
- R4: Command code 3'b010 (SUB) writes register[src_b] − register[src_a], modulo 2^32, into register[dst]. The operand order is reversed.
- R5: Command code 3'b011 (MUL) writes the low 32 bits of register[src_a] × register[src_b] into register[dst].
- R6: Command code 3'b101 (LOAD) writes the 32-bit immediate into register[dst].
- R7: Command code 3'b110 (READ) places register[dst] on `out_data_o`, with `out_valid_o` high, in the cycle after the command is presented. `out_valid_o` is low in every other cycle, and `out_data_o` keeps its last value until the next READ.
- R8: Command code 3'b100 (CJE) with register[src_a] equal to register[src_b] raises `jump_o` and `flush_o` together for exactly the one cycle after the command. It writes no register.
- R9: CJE with unequal operands leaves `jump_o` and `flush_o` low and writes no register.
- R10: Command code 3'b111 (NOP) writes no register, whatever its index and immediate fields hold. It leaves `out_data_o` unchanged and `out_valid_o` low.
- R11: An instruction presented in the cycle right after a register write reads the newly written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_i | input | 3 | Command code |
| src_a_i | input | 4 | First source register index |
| src_b_i | input | 4 | Second source register index |
| dst_i | input | 4 | Destination register index (also the READ source) |
| imm_i | input | 32 | Immediate for LOAD, zero otherwise |
| out_data_o | output | 32 | External output data, updated by READ |
| out_valid_o | output | 1 | One-cycle strobe marking a completed READ |
| jump_o | output | 1 | Taken-branch indication |
| flush_o | output | 1 | Squash request to upstream stages |

## Verification
The hardest state to reach from the ports is a register holding a specific value after a chain of arithmetic. The register file can only be observed through READ. Every operation therefore becomes a sequence: LOAD known seeds into all 16 registers, run the operation over all 256 source pairs, and read the destination back at once. The destination is varied so that sources are overwritten, and the same index is used for both operands. This checks each result and also that the next instruction sees it. Seeds include 0, 1 and all-ones so that the modular wrap of ADD, SUB and MUL occurs, and CJE is driven with equal, unequal and identical-index operands.

// File: rtl/mcu_exec_pkg.sv
package mcu_exec_pkg;

    typedef enum logic [2:0] {
        CMD_MOVE = 3'b000,
        CMD_ADD  = 3'b001,
        CMD_SUB  = 3'b010,
        CMD_MUL  = 3'b011,
        CMD_CJE  = 3'b100,
        CMD_LOAD = 3'b101,
        CMD_READ = 3'b110,
        CMD_NOP  = 3'b111
    } cmd_e;

endpackage

// File: rtl/mcu_regfile.sv
module mcu_regfile #(
    parameter int DW   = 32,
    parameter int NREG = 16,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr_a,
    input  logic [AW-1:0] raddr_b,
    output logic [DW-1:0] rdata_a,
    output logic [DW-1:0] rdata_b
);

    logic [DW-1:0] ent_d [NREG];
    logic [DW-1:0] ent_q [NREG];

    // Next value of each entry: per-entry write decode.
    for (genvar g = 0; g < NREG; g++) begin : g_ent
        assign ent_d[g] = (we && (waddr == AW'(g))) ? wdata : ent_q[g];
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NREG; i++) begin
            if (rst) ent_q[i] <= '0;
            else     ent_q[i] <= ent_d[i];
        end
    end

    always_comb begin
        rdata_a = ent_q[raddr_a];
        rdata_b = ent_q[raddr_b];
    end

endmodule

// File: rtl/mcu_alu.sv
module mcu_alu
    import mcu_exec_pkg::*;
#(
    parameter int DW = 32
) (
    input  cmd_e          cmd,
    input  logic [DW-1:0] opa,
    input  logic [DW-1:0] opb,
    input  logic [DW-1:0] imm,
    output logic [DW-1:0] res,
    output logic          wr_en,
    output logic          rd_out,
    output logic          br_take
);

    always_comb begin
        res     = '0;
        wr_en   = 1'b0;
        rd_out  = 1'b0;
        br_take = 1'b0;
        unique case (cmd)
            CMD_MOVE: begin res = opa;       wr_en = 1'b1; end
            CMD_ADD:  begin res = opa + opb; wr_en = 1'b1; end
            CMD_SUB:  begin res = opb - opa; wr_en = 1'b1; end
            CMD_MUL:  begin res = opa * opb; wr_en = 1'b1; end
            CMD_LOAD: begin res = imm;       wr_en = 1'b1; end
            CMD_CJE:  br_take = (opa == opb);
            CMD_READ: rd_out  = 1'b1;
            CMD_NOP:  ;
            default:  ;
        endcase
    end

endmodule

// File: rtl/mcu_exec_stage.sv
module mcu_exec_stage
    import mcu_exec_pkg::*;
#(
    parameter int DW   = 32,
    parameter int NREG = 16,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [2:0]    cmd_i,
    input  logic [AW-1:0] src_a_i,
    input  logic [AW-1:0] src_b_i,
    input  logic [AW-1:0] dst_i,
    input  logic [DW-1:0] imm_i,
    output logic [DW-1:0] out_data_o,
    output logic          out_valid_o,
    output logic          jump_o,
    output logic          flush_o
);

    typedef struct packed {
        logic [DW-1:0] out_data;
        logic          out_valid;
        logic          jump;
        logic          flush;
    } state_t;

    state_t        st_d, st_q;
    cmd_e          cmd;
    logic [AW-1:0] raddr_a;
    logic [DW-1:0] opa, opb, res;
    logic          wr_en, rd_out, br_take;

    assign cmd     = cmd_e'(cmd_i);
    // READ names its register in the destination field.
    assign raddr_a = (cmd == CMD_READ) ? dst_i : src_a_i;

    mcu_regfile #(.DW(DW), .NREG(NREG)) u_rf (
        .clk     (clk),
        .rst     (rst),
        .we      (wr_en),
        .waddr   (dst_i),
        .wdata   (res),
        .raddr_a (raddr_a),
        .raddr_b (src_b_i),
        .rdata_a (opa),
        .rdata_b (opb)
    );

    mcu_alu #(.DW(DW)) u_alu (
        .cmd     (cmd),
        .opa     (opa),
        .opb     (opb),
        .imm     (imm_i),
        .res     (res),
        .wr_en   (wr_en),
        .rd_out  (rd_out),
        .br_take (br_take)
    );

    always_comb begin
        st_d           = st_q;
        st_d.out_valid = rd_out;
        st_d.jump      = br_take;
        st_d.flush     = br_take;
        if (rd_out) st_d.out_data = opa;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign out_data_o  = st_q.out_data;
    assign out_valid_o = st_q.out_valid;
    assign jump_o      = st_q.jump;
    assign flush_o     = st_q.flush;

endmodule

// File: rtl/mcu_exec_chk.sv
module mcu_exec_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic [2:0]    cmd_i,
    input logic [DW-1:0] opa,
    input logic [DW-1:0] opb,
    input logic [DW-1:0] out_data_o,
    input logic          out_valid_o,
    input logic          jump_o,
    input logic          flush_o
);

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (out_data_o == '0 && !out_valid_o && !jump_o && !flush_o));

    a_r7_strobe_after_read: assert property (@(posedge clk) disable iff (rst)
        (cmd_i == 3'b110) |=> out_valid_o);

    a_r7_no_strobe_otherwise: assert property (@(posedge clk) disable iff (rst)
        (cmd_i != 3'b110) |=> !out_valid_o);

    a_r8_jump_with_flush: assert property (@(posedge clk) disable iff (rst)
        jump_o == flush_o);

    a_r8_equal_branches: assert property (@(posedge clk) disable iff (rst)
        (cmd_i == 3'b100 && opa == opb) |=> jump_o);

    a_r9_no_branch: assert property (@(posedge clk) disable iff (rst)
        !(cmd_i == 3'b100 && opa == opb) |=> !jump_o);

    a_r10_nop_holds_port: assert property (@(posedge clk) disable iff (rst)
        (cmd_i == 3'b111) |=> $stable(out_data_o));

endmodule

bind mcu_exec_stage mcu_exec_chk #(.DW(DW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cmd_i       (cmd_i),
    .opa         (opa),
    .opb         (opb),
    .out_data_o  (out_data_o),
    .out_valid_o (out_valid_o),
    .jump_o      (jump_o),
    .flush_o     (flush_o)
);

// File: tb/tb_mcu_exec_stage.sv
module tb_mcu_exec_stage;

    localparam logic [2:0] C_MOVE = 3'b000, C_ADD = 3'b001, C_SUB = 3'b010,
                           C_MUL  = 3'b011, C_CJE = 3'b100, C_LOAD = 3'b101,
                           C_READ = 3'b110, C_NOP = 3'b111;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  cmd = C_NOP;
    logic [3:0]  sa = '0, sb = '0, dd = '0;
    logic [31:0] imm = '0;
    logic [31:0] out_data;
    logic        out_valid, jump, flush;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;
    logic [31:0] model [16];

    always #10 clk = ~clk;

    mcu_exec_stage dut (
        .clk(clk), .rst(rst), .cmd_i(cmd), .src_a_i(sa), .src_b_i(sb),
        .dst_i(dd), .imm_i(imm), .out_data_o(out_data),
        .out_valid_o(out_valid), .jump_o(jump), .flush_o(flush)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    // Present one instruction for one cycle; sample 2 ns after the edge.
    task automatic issue(input logic [2:0] c, input logic [3:0] a, input logic [3:0] b,
                         input logic [3:0] d, input logic [31:0] im);
        @(negedge clk);
        cmd = c; sa = a; sb = b; dd = d; imm = im;
        @(posedge clk);
        #2;
        cmd = C_NOP; sa = '0; sb = '0; dd = '0; imm = '0;
    endtask

    function automatic logic [31:0] ref_op(input logic [2:0] c, input logic [31:0] x,
                                           input logic [31:0] y, input logic [31:0] im);
        case (c)
            C_MOVE:  return x;
            C_ADD:   return x + y;
            C_SUB:   return y - x;
            C_MUL:   return x * y;
            C_LOAD:  return im;
            default: return 32'h0;
        endcase
    endfunction

    task automatic exec(input logic [2:0] c, input logic [3:0] a, input logic [3:0] b,
                        input logic [3:0] d, input logic [31:0] im);
        logic [31:0] r;
        r = ref_op(c, model[a], model[b], im);
        issue(c, a, b, d, im);
        if (c != C_CJE && c != C_READ && c != C_NOP) model[d] = r;
    endtask

    task automatic read_chk(input string tag, input logic [3:0] r);
        issue(C_READ, 4'd0, 4'd0, r, 32'h0);
        check(tag, out_data, model[r]);
        check({tag, " strobe"}, {31'h0, out_valid}, 32'h1);
    endtask

    function automatic logic [31:0] seed(input int i);
        if (i == 0)  return 32'h0;
        if (i == 1)  return 32'h1;
        if (i == 15) return 32'hFFFF_FFFF;
        return 32'h9E37_79B9 * (i + 1) ^ 32'h0F0F_0F0F;
    endfunction

    task automatic load_all();
        for (int i = 0; i < 16; i++) exec(C_LOAD, 4'd0, 4'd0, 4'(i), seed(i));
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) model[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        // R1: reset state at the ports and in every register.
        check("R1 out_data", out_data, 32'h0);
        check("R1 strobe/jump/flush", {29'h0, out_valid, jump, flush}, 32'h0);
        for (int i = 0; i < 16; i++) read_chk("R1 reg cleared", 4'(i));

        // R6 / R7: load seeds, read every register back.
        load_all();
        for (int i = 0; i < 16; i++) read_chk("R6 R7 load/read", 4'(i));

        // R2 R3 R4 R5 sweeps over all source pairs; R11 via immediate read-back.
        for (int o = 0; o < 4; o++) begin
            logic [2:0] op;
            string tag;
            op = (o == 0) ? C_MOVE : (o == 1) ? C_ADD : (o == 2) ? C_SUB : C_MUL;
            tag = (o == 0) ? "R2 MOVE" : (o == 1) ? "R3 ADD" : (o == 2) ? "R4 SUB" : "R5 MUL";
            load_all();
            for (int a = 0; a < 16; a++) begin
                for (int b = 0; b < 16; b++) begin
                    logic [3:0] d;
                    d = 4'((a + 3 * b) % 16);
                    exec(op, 4'(a), 4'(b), d, 32'h0);
                    read_chk(tag, d);
                end
            end
        end

        // R4: reversed operand order, explicit value.
        exec(C_LOAD, 0, 0, 4'd2, 32'd5);
        exec(C_LOAD, 0, 0, 4'd3, 32'd12);
        exec(C_SUB, 4'd2, 4'd3, 4'd4, 32'h0);
        read_chk("R4 src2-src1", 4'd4);
        check("R4 value 7", model[4], 32'd7);

        // R11: dependent chain with no gap.
        exec(C_LOAD, 0, 0, 4'd6, 32'h0000_1000);
        exec(C_ADD, 4'd6, 4'd6, 4'd6, 32'h0);
        exec(C_ADD, 4'd6, 4'd6, 4'd7, 32'h0);
        read_chk("R11 back-to-back", 4'd7);
        check("R11 value", model[7], 32'h0000_4000);

        // R10: NOP after READ keeps port, drops strobe, writes nothing.
        read_chk("R10 setup", 4'd7);
        issue(C_NOP, 4'd1, 4'd2, 4'd7, 32'hDEAD_BEEF);
        check("R10 port held", out_data, model[7]);
        check("R10 strobe low", {31'h0, out_valid}, 32'h0);
        read_chk("R10 no write", 4'd7);

        // R8: equal CJE, one-cycle jump and flush, no write.
        exec(C_LOAD, 0, 0, 4'd8, 32'h1234_5678);
        exec(C_LOAD, 0, 0, 4'd9, 32'h1234_5678);
        exec(C_LOAD, 0, 0, 4'd10, 32'hA5A5_A5A5);
        exec(C_CJE, 4'd8, 4'd9, 4'd10, 32'h0);
        check("R8 jump", {31'h0, jump}, 32'h1);
        check("R8 flush", {31'h0, flush}, 32'h1);
        issue(C_NOP, 0, 0, 0, 32'h0);
        check("R8 one cycle", {30'h0, jump, flush}, 32'h0);
        read_chk("R8 no write", 4'd10);
        exec(C_CJE, 4'd10, 4'd10, 4'd10, 32'h0);
        check("R8 same index", {30'h0, jump, flush}, 32'h3);

        // R9: unequal CJE.
        exec(C_CJE, 4'd8, 4'd10, 4'd8, 32'h0);
        check("R9 no jump", {30'h0, jump, flush}, 32'h0);
        read_chk("R9 no write", 4'd8);

        // R1: reset mid-run clears again.
        @(negedge clk) rst = 1'b1;
        @(posedge clk); #2;
        rst = 1'b0;
        for (int i = 0; i < 16; i++) model[i] = '0;
        check("R1 rerun port", {out_data[30:0], out_valid}, 32'h0);
        read_chk("R1 rerun reg", 4'd7);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule